// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block keeps a multiplexed-address DRAM refreshed. It runs refresh cycles in which both column strobes go low before the row strobe, so the memory uses its internal row counter and ignores the address pins. A free-running interval timer creates refresh debts. While a debt is open, the block raises a request to the access sequencer that owns the memory bus. Once the sequencer grants the bus, the block drives the strobe sequence itself and then hands the bus back.

After reset the memory needs a quiet power-up pause and then a burst of refresh cycles before normal traffic may start. The scheduler runs this pause, requests and performs the initialization refreshes, and raises a ready flag when the last one has finished its precharge. If the sequencer is slow to grant, debts build up in a counter with a fixed ceiling. The owed refreshes then run back to back as soon as grants come.

All durations are parameters in clock cycles: pause length, refresh interval, number of initialization cycles, CAS-to-RAS setup, RAS low time, precharge time and the debt ceiling.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and at the first cycle after it, `ras_n` is 1, `cas_n` is 2'b11, `ref_req` is 0 and `init_done` is 0.
- R2: After reset is released, `ref_req` first rises exactly PAUSE_CYC clock cycles later. No strobe goes low before that.
- R3: In a refresh, both column strobes (`cas_n` = 2'b00) go low SETUP_CYC cycles before `ras_n` falls. They stay low for the whole time `ras_n` is low, and rise in the same cycle as `ras_n`.
- R4: `ras_n` stays low for RAS_CYC cycles. It is followed by PRE_CYC cycles with every strobe high and `ref_req` low.
- R5: After the pause, INIT_CYCLES refreshes are requested. `init_done` stays 0 until the last of them has finished its precharge. It is 1 from the next cycle on and never falls again until reset.
- R6: `ref_req` stays high until `ref_gnt` is sampled high, and no strobe moves without a grant. A grant makes `cas_n` fall in the next cycle and drops `ref_req`.
- R7: Once `init_done` is 1, a refresh debt is added every INTERVAL_CYC cycles. The first request after initialization appears INTERVAL_CYC cycles after `init_done` rises.
- R8: Debts that are not granted accumulate up to OWED_MAX and no further. Owed refreshes run back to back: `ref_req` is high again in the first cycle after each precharge while debt remains.
- R9: `ref_gnt` has no effect while `ref_req` is low. Strobes stay high and no refresh is started or consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Bus grant from the access sequencer |
| ref_req | output | 1 | Refresh request to the access sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Both column strobes, active low, driven together |
| init_done | output | 1 | Power-up pause and initialization burst complete |

## Verification
The bench counts cycles from reset release to the first request. A pause counter off by one shifts this by a cycle. It then walks every refresh phase cycle by cycle. A sequencer that drops RAS first, or lets CAS rise early, would break the refresh ordering in the memory, and the phase checks report it. It withholds grants for eleven intervals and then counts the refreshes that follow. A counter without a ceiling would give twelve, and a counter that drops debts would give fewer. It also checks that `init_done` stays low through the seventh initialization refresh and rises just after the eighth precharge, and that a stray grant while idle moves no strobe.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC    = 10000,
  parameter int INTERVAL_CYC = 780,
  parameter int INIT_CYCLES  = 8,
  parameter int OWED_MAX     = 8,
  parameter int SETUP_CYC    = 1,
  parameter int RAS_CYC      = 3,
  parameter int PRE_CYC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_gnt,
  output logic       ref_req,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       init_done
);
  localparam int CW = $clog2(PAUSE_CYC + SETUP_CYC + RAS_CYC + PRE_CYC + 1);
  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam int OMAX = (INIT_CYCLES > OWED_MAX) ? INIT_CYCLES : OWED_MAX;
  localparam int OW = $clog2(OMAX + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_SETUP, S_ACT, S_PRE} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic [OW-1:0] owed, owed_nxt;
  logic          take, tick, pause_end;

  assign ref_req   = (st == S_IDLE) && (owed != '0);
  assign take      = ref_req && ref_gnt;
  assign tick      = init_done && (tmr == TW'(INTERVAL_CYC - 1));
  assign pause_end = (st == S_PAUSE) && (cnt == CW'(PAUSE_CYC - 1));
  assign ras_n     = (st != S_ACT);
  assign cas_n     = (st == S_SETUP || st == S_ACT) ? 2'b00 : 2'b11;

  always_comb begin
    owed_nxt = owed;
    if (pause_end) owed_nxt = OW'(INIT_CYCLES);
    else if (tick && !take && owed != OW'(OWED_MAX)) owed_nxt = owed + 1'b1;
    else if (take && !tick) owed_nxt = owed - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      cnt       <= '0;
      tmr       <= '0;
      owed      <= '0;
      init_done <= 1'b0;
    end else begin
      tmr  <= (!init_done || tick) ? '0 : tmr + 1'b1;
      owed <= owed_nxt;
      case (st)
        S_PAUSE: if (pause_end) begin st <= S_IDLE; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        S_IDLE:  if (take) begin st <= S_SETUP; cnt <= '0; end
        S_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin st <= S_ACT; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        S_ACT:   if (cnt == CW'(RAS_CYC - 1)) begin st <= S_PRE; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        S_PRE:   if (cnt == CW'(PRE_CYC - 1)) begin
                   st  <= S_IDLE;
                   cnt <= '0;
                   if (!init_done && owed == '0) init_done <= 1'b1;
                 end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (cas_n == 2'b00) && ($past(cas_n) == 2'b00));
  p_cas_covers_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> cas_n == 2'b00);
  p_req_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_gnt |=> ref_req);
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_owed_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> owed <= OW'(OWED_MAX));
  p_quiet_until_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !ref_req && cas_n == 2'b11) |=> (ras_n && (cas_n == 2'b11 || $past(ref_req))));
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int PAUSE = 20, INTV = 100, INIT = 8, OMAX = 8, SETUP = 2, RASC = 5, PRE = 3;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ras_n, init_done;
  logic [1:0] cas_n;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .INIT_CYCLES(INIT),
    .OWED_MAX(OMAX), .SETUP_CYC(SETUP), .RAS_CYC(RASC), .PRE_CYC(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_refresh();
    int bad_s = 0, bad_a = 0, bad_p = 0;
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    for (int i = 0; i < SETUP; i++) begin
      if (!(cas_n == 2'b00 && ras_n && !ref_req)) bad_s++;
      @(negedge clk);
    end
    for (int i = 0; i < RASC; i++) begin
      if (!(cas_n == 2'b00 && !ras_n && !ref_req)) bad_a++;
      @(negedge clk);
    end
    for (int i = 0; i < PRE; i++) begin
      if (!(cas_n == 2'b11 && ras_n && !ref_req)) bad_p++;
      @(negedge clk);
    end
    chk(bad_s == 0, "R3 cas setup phase", bad_s, 0);
    chk(bad_a == 0, "R3/R4 ras low phase", bad_a, 0);
    chk(bad_p == 0, "R4 precharge phase", bad_p, 0);
  endtask

  task automatic t_reset();
    #5;
    chk(ras_n && cas_n == 2'b11 && !ref_req && !init_done, "R1 reset outputs",
        {ras_n, cas_n, ref_req, init_done}, 5'b11100);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk(ras_n && cas_n == 2'b11 && !ref_req && !init_done, "R1 after release",
        {ras_n, cas_n, ref_req, init_done}, 5'b11100);
  endtask

  task automatic t_pause();
    int n = 0, strobes = 0;
    while (!ref_req && n < 1000) begin
      @(negedge clk);
      n++;
      if (!ras_n || cas_n != 2'b11) strobes++;
    end
    chk(n == PAUSE, "R2 pause length", n, PAUSE);
    chk(strobes == 0, "R2 no strobes in pause", strobes, 0);
  endtask

  task automatic t_hold();
    int bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!ref_req || !ras_n || cas_n != 2'b11) bad++;
    end
    chk(bad == 0, "R6 request held without grant", bad, 0);
  endtask

  task automatic t_init();
    for (int k = 1; k <= INIT; k++) begin
      chk(ref_req, "R5 init request pending", ref_req, 1);
      do_refresh();
      if (k == INIT - 1) chk(!init_done, "R5 not ready before last", init_done, 0);
    end
    chk(init_done, "R5 ready after last precharge", init_done, 1);
    chk(!ref_req, "R5 no extra init request", ref_req, 0);
  endtask

  task automatic t_interval();
    int n = 0;
    while (!ref_req && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == INTV, "R7 first interval", n, INTV);
    chk(init_done, "R5 ready stays high", init_done, 1);
  endtask

  task automatic t_saturate();
    int done = 0, bad_b2b = 0;
    repeat (11 * INTV + 2) @(negedge clk);
    while (ref_req && done < 20) begin
      do_refresh();
      done++;
      if (done < OMAX && !ref_req) bad_b2b++;
    end
    chk(done == OMAX, "R8 owed refreshes capped", done, OMAX);
    chk(bad_b2b == 0, "R8 back to back issue", bad_b2b, 0);
  endtask

  task automatic t_stray_grant();
    int bad = 0;
    ref_gnt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!ras_n || cas_n != 2'b11 || ref_req) bad++;
    end
    ref_gnt = 1'b0;
    chk(bad == 0, "R9 grant ignored while idle", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_pause();
    t_hold();
    t_init();
    t_interval();
    t_saturate();
    t_stray_grant();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule